// File: doc/BRIEF.md
# Gated Oscillator Binary Divider Chain

This block divides a free-running oscillator by successive powers of two through fourteen cascaded halving stages. It is modelled as a single 14-bit counter that steps on each falling edge of the oscillator input. A subset of the stage outputs is brought out as frequency taps. An active-high asynchronous reset clears the chain at once. While reset is held, the block also drops an enable that stops the oscillator, so the part draws little power in standby.

A decode strobe compares the full count with a programmable match word. The count changes on the falling oscillator edge, so the strobe is only allowed through while the oscillator level is high. Any settling mismatch around the count update therefore never reaches the strobe. Typical uses are a real-time tick derived from a crystal and a one-shot event at a chosen count.

Top module: `osc_div_chain`

## Requirements
- R1: Stage k (k = 1..14) toggles at half the rate of stage k-1, so the output of stage k has a period of 2^k oscillator periods.
- R2: The count steps by exactly one on each falling edge of `osc_i`. A rising edge or a steady level leaves it unchanged.
- R3: While `rst_i` is high, `taps_o` and `strobe_o` are all zero at once, with no oscillator edge needed.
- R4: `run_en_o` is low whenever `rst_i` is high, and returns high as soon as `rst_i` falls.
- R5: `taps_o[6:0]` carry stages 4 to 10 in ascending order, and `taps_o[9:7]` carry stages 12 to 14. Stages 1 to 3 and stage 11 never appear on any port.
- R6: `strobe_o` is low whenever `osc_i` is low.
- R7: `strobe_o` is high during a high half-period of `osc_i` exactly when the 14-bit count equals `match_i`. It gives one such half-period for each visit of the count to the match value.
- R8: After reset is released, the N-th falling edge of `osc_i` leaves the count equal to N.
- R9: The count wraps from 16383 to 0, so after 16384 falling edges every tap is low again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_i | input | 1 | Oscillator level; the count steps on its falling edge |
| rst_i | input | 1 | Asynchronous active-high clear and standby request |
| match_i | input | 14 | Count value at which the decode strobe fires |
| run_en_o | output | 1 | High when the oscillator may run |
| taps_o | output | 10 | Exposed stage outputs (stages 4-10, 12-14) |
| strobe_o | output | 1 | Phase-qualified decode of count equal to match |

## Verification
The bound checker watches four things on every oscillator edge: the single-step count increment, the wrap from all ones to zero, a low strobe throughout each low half-period, and a strobe seen in a high phase only when the count equals the match word. The bench scenarios cover the rest. They measure each tap's period, so the stage ratios and the choice of which stages are exposed are shown. They assert reset in mid-phase and observe the clear with no edge. They also show the oscillator enable dropping and returning, and they confirm that the strobe fires exactly once per pass of the count through the match value.

// File: rtl/odc_pkg.sv
// Shared constants and helpers for the oscillator divider chain.
// Assumes exactly one internal stage lies between the first exposed stage and the last stage.
package odc_pkg;
    localparam int ODC_STAGES     = 14;  // halving stages in the chain
    localparam int ODC_FIRST_TAP  = 4;   // lowest stage brought out
    localparam int ODC_HIDDEN_TAP = 11;  // stage kept internal above the first tap

    // Stage number driving tap index j, skipping the hidden stage.
    function automatic int tap_stage(input int first, input int hidden, input int j);
        int s;
        s = first + j;
        if (s >= hidden) s = s + 1;
        return s;
    endfunction
endpackage

// File: rtl/odc_counter.sv
// Counter that stands in for the ripple chain: bit k-1 is the output of stage k.
// Steps on the falling oscillator edge and clears asynchronously on reset.
// Assumes reset is released while the oscillator is stopped or well clear of a falling edge.
module odc_counter #(
    parameter int W = 14
) (
    input  logic         osc_i,
    input  logic         rst_i,
    output logic [W-1:0] count_o
);
    // Purpose: advance on each falling oscillator edge, wrapping naturally at 2^W.
    always_ff @(negedge osc_i or posedge rst_i) begin
        if (rst_i) count_o <= '0;
        else       count_o <= count_o + 1'b1;
    end
endmodule

// File: rtl/odc_run_gate.sv
// Oscillator run enable: holds the oscillator off for the whole time reset is high.
// Assumes the oscillator stops within its current half-period once the enable falls.
module odc_run_gate (
    input  logic rst_i,
    output logic run_en_o
);
    // Purpose: release the oscillator as soon as the reset request is removed.
    always_comb run_en_o = ~rst_i;
endmodule

// File: rtl/odc_decode.sv
// Decode strobe: full-count compare qualified by the high oscillator phase.
// The count only changes on the falling edge, so it is stable while osc is high.
module odc_decode #(
    parameter int W = 14
) (
    input  logic         osc_i,
    input  logic         rst_i,
    input  logic [W-1:0] count_i,
    input  logic [W-1:0] match_i,
    output logic         strobe_o
);
    logic hit;

    // Purpose: raw equality of the count and the programmed match word.
    always_comb hit = (count_i == match_i);

    // Purpose: pass the hit only in the settled high phase and never under reset.
    always_comb strobe_o = hit & osc_i & ~rst_i;
endmodule

// File: rtl/osc_div_chain.sv
// Top of the gated oscillator divider chain.
// Exposes a subset of stage outputs, an oscillator enable and a phase-qualified decode.
// Assumes the oscillator is the only clock; all state is in its falling-edge domain.
module osc_div_chain
    import odc_pkg::*;
#(
    parameter int STAGES     = ODC_STAGES,
    parameter int FIRST_TAP  = ODC_FIRST_TAP,
    parameter int HIDDEN_TAP = ODC_HIDDEN_TAP,
    localparam int NT        = STAGES - FIRST_TAP
) (
    input  logic              osc_i,
    input  logic              rst_i,
    input  logic [STAGES-1:0] match_i,
    output logic              run_en_o,
    output logic [NT-1:0]     taps_o,
    output logic              strobe_o
);
    logic [STAGES-1:0] count_q;

    odc_run_gate u_gate (
        .rst_i    (rst_i),
        .run_en_o (run_en_o)
    );

    odc_counter #(.W(STAGES)) u_cnt (
        .osc_i   (osc_i),
        .rst_i   (rst_i),
        .count_o (count_q)
    );

    // Purpose: route each exposed stage to its tap, skipping the hidden stage.
    for (genvar j = 0; j < NT; j++) begin : g_tap
        localparam int S = tap_stage(FIRST_TAP, HIDDEN_TAP, j);
        assign taps_o[j] = count_q[S-1];
    end

    odc_decode #(.W(STAGES)) u_dec (
        .osc_i    (osc_i),
        .rst_i    (rst_i),
        .count_i  (count_q),
        .match_i  (match_i),
        .strobe_o (strobe_o)
    );
endmodule

// File: rtl/odc_checker.sv
// Property checker bound into the divider top; observes the counter and the strobe.
module odc_checker #(
    parameter int W = 14
) (
    input logic         osc_i,
    input logic         rst_i,
    input logic [W-1:0] cnt,
    input logic [W-1:0] match_i,
    input logic         strobe_o
);
    logic armed;

    // Purpose: mark that at least one falling edge has passed since reset.
    always_ff @(negedge osc_i or posedge rst_i) begin
        if (rst_i) armed <= 1'b0;
        else       armed <= 1'b1;
    end

    // R2: one step per falling edge
    a_r2_single_step: assert property (@(negedge osc_i) disable iff (rst_i)
        armed |-> (cnt == W'($past(cnt) + 1'b1)));

    // R9: all ones is followed by zero
    a_r9_wrap: assert property (@(negedge osc_i) disable iff (rst_i)
        (armed && ($past(cnt) == {W{1'b1}})) |-> (cnt == '0));

    // R6: strobe stays low through the low phase (sampled just before the rise)
    a_r6_low_phase_quiet: assert property (@(posedge osc_i) disable iff (rst_i)
        !strobe_o);

    // R7: a strobe in the high phase implies a count match
    a_r7_strobe_match: assert property (@(negedge osc_i) disable iff (rst_i)
        strobe_o |-> (cnt == match_i));
endmodule

bind osc_div_chain odc_checker #(.W(STAGES)) u_chk (
    .osc_i    (osc_i),
    .rst_i    (rst_i),
    .cnt      (count_q),
    .match_i  (match_i),
    .strobe_o (strobe_o)
);

// File: tb/osc_div_chain_test.sv
`timescale 1ns/1ps
module osc_div_chain_test;
    localparam int NT = 10;
    localparam int NV = 8;
    localparam int VEC_N [NV] = '{7, 8, 1023, 1024, 2048, 16383, 16384, 3};
    localparam logic [NT-1:0] VEC_T [NV] =
        '{10'h000, 10'h001, 10'h07F, 10'h000, 10'h080, 10'h3FF, 10'h000, 10'h000};

    logic osc = 1'b0;
    logic rst = 1'b1;
    logic [13:0] match = '0;
    logic run_en;
    logic [NT-1:0] taps;
    logic strobe;
    int checks = 0;
    int errors = 0;

    osc_div_chain uut (
        .osc_i(osc), .rst_i(rst), .match_i(match),
        .run_en_o(run_en), .taps_o(taps), .strobe_o(strobe)
    );

    // 50 MHz oscillator model that halts while the enable is low
    always begin
        #10;
        if (run_en) osc = ~osc;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int stage_of(input int j);
        return (j < 7) ? 4 + j : 5 + j;
    endfunction

    function automatic logic [NT-1:0] model_taps(input int n);
        logic [NT-1:0] t;
        int m;
        m = n % 16384;
        for (int j = 0; j < NT; j++) t[j] = 1'((m >> (stage_of(j) - 1)) & 1);
        return t;
    endfunction

    // Stop the oscillator in its low phase, then release reset
    task automatic do_reset();
        if (run_en) begin
            @(negedge osc);
            #2;
        end
        rst = 1'b1;
        #30;
        rst = 1'b0;
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge osc);
        #3;
    endtask

    initial begin
        #200000;
        #2800000;
        checks++;
        errors++;
        $display("FAIL watchdog run did not finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int first_rise [NT];
        int second_rise [NT];
        logic [NT-1:0] prev;
        int hi_mis, lo_mis, hi_cnt;

        // Reset state, oscillator halted
        #5;
        check(taps == '0, "R3", "taps in reset", taps, 0);
        check(strobe == 1'b0, "R3", "strobe in reset", strobe, 0);
        check(run_en == 1'b0, "R4", "run_en in reset", run_en, 0);

        // Table walk: edges since reset vs expected taps
        for (int v = 0; v < NV; v++) begin
            do_reset();
            edges(VEC_N[v]);
            check(taps == VEC_T[v], "R5/R8/R9", $sformatf("taps after %0d edges", VEC_N[v]),
                  taps, VEC_T[v]);
        end

        // Asynchronous clear in mid high phase, no edge involved
        do_reset();
        edges(100);
        check(taps == model_taps(100), "R8", "taps after 100 edges", taps, model_taps(100));
        match = 14'd100;
        @(posedge osc);
        #4;
        check(strobe == 1'b1, "R7", "strobe on match in high phase", strobe, 1);
        rst = 1'b1;
        #1;
        check(taps == '0, "R3", "taps cleared without edge", taps, 0);
        check(strobe == 1'b0, "R3", "strobe cleared without edge", strobe, 0);
        check(run_en == 1'b0, "R4", "run_en dropped", run_en, 0);
        match = 14'd0;
        #40;
        check(strobe == 1'b0, "R7", "no strobe under reset with match 0", strobe, 0);
        check(osc == 1'b1, "R4", "oscillator held while stopped", osc, 1);
        rst = 1'b0;
        #1;
        check(run_en == 1'b1, "R4", "run_en back on release", run_en, 1);
        edges(1);
        check(taps == '0, "R8", "taps after first edge", taps, 0);
        edges(7);
        check(taps == 10'h001, "R8", "taps after eighth edge", taps, 10'h001);
        #4;
        check(taps == 10'h001, "R2", "steady level holds count", taps, 10'h001);
        @(posedge osc);
        #3;
        check(taps == 10'h001, "R2", "rising edge holds count", taps, 10'h001);

        // Long run: tap periods and strobe phase behaviour
        match = 14'd5000;
        do_reset();
        for (int j = 0; j < NT; j++) begin
            first_rise[j] = -1;
            second_rise[j] = -1;
        end
        prev = taps;
        hi_mis = 0;
        lo_mis = 0;
        hi_cnt = 0;
        for (int e = 1; e <= 30000; e++) begin
            @(posedge osc);
            #5;
            if (strobe) hi_cnt++;
            if (strobe != (((e - 1) % 16384) == 5000)) hi_mis++;
            @(negedge osc);
            #3;
            if (strobe) lo_mis++;
            for (int j = 0; j < NT; j++) begin
                if (!prev[j] && taps[j]) begin
                    if (first_rise[j] < 0) first_rise[j] = e;
                    else if (second_rise[j] < 0) second_rise[j] = e;
                end
            end
            prev = taps;
        end
        for (int j = 0; j < NT; j++) begin
            check(second_rise[j] - first_rise[j] == (1 << stage_of(j)), "R1",
                  $sformatf("period of stage %0d", stage_of(j)),
                  second_rise[j] - first_rise[j], 1 << stage_of(j));
        end
        check(lo_mis == 0, "R6", "strobe samples in low phase", lo_mis, 0);
        check(hi_mis == 0, "R7", "strobe mismatches in high phase", hi_mis, 0);
        check(hi_cnt == 2, "R7", "strobe pulses in two passes", hi_cnt, 2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule